// File: doc/BRIEF.md
# Watchdog Timer with Timed Register Unlock

The block is a watchdog counter that requests a system reset when software stops kicking it. Its single control register holds an enable bit, an unlock bit and a 3-bit timeout select. Two of those fields are guarded: turning the watchdog off and changing its timeout both need a two-write sequence. The first write arms a short window. The second write, which must land within four clocks of the first, applies the new values.

A strap input picks one of two protection levels and is latched while reset is held. At the relaxed level the watchdog starts disabled, and software may switch it on with one plain write. At the strict level the watchdog always runs, so only the timeout select is guarded. A kick pulse restarts the count. When the count reaches the selected timeout, the block raises a reset request for one clock.

Top module: `wdog_top`

## Requirements
- R1: Register layout: bit 0 is enable, bit 1 is unlock (reads 1 while the window is open), bits 4:2 are the timeout select. At the relaxed level (strap 0), reset leaves the register reading 0x00. A plain write with bit 0 set turns the watchdog on at any time.
- R2: At the relaxed level, clearing a set enable bit takes effect only through a second write made inside the unlock window.
- R3: Only a write with bits 1 and 0 both set opens the window. A write with bit 1 set and bit 0 clear opens nothing.
- R4: A write with bit 1 clear, landing in any of the four clocks after the opening write, loads the timeout select (and, at the relaxed level, the enable bit). The window then closes.
- R5: At the strict level (strap 1), bit 0 always reads 1. The enable value carried by a second write is ignored, and the watchdog keeps running.
- R6: If no second write comes, the unlock bit reads 1 for four clocks and then clears on its own. A write in the fifth clock after the opening write is treated as unguarded.
- R7: An unguarded write leaves the timeout select unchanged. At the relaxed level it cannot clear the enable bit, and at the strict level it changes nothing.
- R8: With the select at n, the reset request goes high 2^(10+n) clocks after the count was cleared. It stays high for exactly one clock, and the count then starts again.
- R9: A kick pulse, or a load that changes the timeout select, clears the count.
- R10: While disabled, the watchdog never raises the reset request.
- R11: The strap is taken only while reset is held. Changing it later has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the strap is latched while it is low |
| safeLevelIn | input | 1 | Protection level strap: 0 relaxed, 1 strict |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 5 | Register write value |
| rdData | output | 5 | Register readback |
| kick | input | 1 | Counter restart pulse |
| rstReq | output | 1 | One-clock reset request on timeout |

## Verification
The register is driven with sequences of plain writes, opening writes, and second writes at gaps of 0 to 4 idle clocks. Comparing a 3-clock gap with a 4-clock gap pins down the exact edge at which the window closes. An opening write with the enable bit clear shows that only the full bit pattern arms the window. Disable and timeout changes are tried both inside and outside the window, at both levels, and the strap is changed after reset to show it is held. The timeout is measured after a kick at two select values, again across a mid-count select change, and under regular kicks, which tells a cleared count apart from one that free-runs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PS_W_P = 3;

  typedef struct packed {
    logic              run;
    logic [PS_W_P-1:0] ps;
    logic              psLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN  = 4,
  parameter int PS_W = PS_W_P,
  localparam int REG_W = PS_W + 2,
  localparam int WIN_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             safeLevelIn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             lvlQ,
  output ctrlStrobe_t      strobe
);
  localparam int EN_B = 0;
  localparam int UL_B = 1;

  logic             enQ;
  logic [PS_W-1:0]  psQ;
  logic [WIN_W-1:0] winCnt;

  logic             winOpen;
  logic             isOpenWr;
  logic             isSecondWr;
  logic [PS_W-1:0]  wrPs;
  logic             enNext;
  logic [PS_W-1:0]  psNext;
  logic [WIN_W-1:0] winNext;

  // The strap is copied on every clock while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rstN) lvlQ <= safeLevelIn;
  end

  assign winOpen    = (winCnt != '0);
  assign wrPs       = wrData[REG_W-1:2];
  assign isOpenWr   = wrEn && wrData[UL_B] && wrData[EN_B];
  assign isSecondWr = wrEn && !wrData[UL_B] && winOpen;

  always_comb begin
    enNext  = enQ;
    psNext  = psQ;
    winNext = winOpen ? winCnt - WIN_W'(1) : '0;
    if (isOpenWr) begin
      winNext = WIN_W'(WIN);
      enNext  = 1'b1;
    end else if (wrEn) begin
      winNext = '0;
      if (isSecondWr) begin
        psNext = wrPs;
        if (!lvlQ) enNext = wrData[EN_B];
      end else if (!lvlQ && wrData[EN_B]) begin
        enNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      psQ    <= '0;
      winCnt <= '0;
    end else begin
      enQ    <= enNext;
      psQ    <= psNext;
      winCnt <= winNext;
    end
  end

  assign strobe.run    = lvlQ || enQ;
  assign strobe.ps     = psQ;
  assign strobe.psLoad = (psNext != psQ);

  assign rdData = {psQ, winOpen, lvlQ || enQ};
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_LOG = 10,
  parameter int PS_W     = PS_W_P,
  localparam int CNT_W   = BASE_LOG + (1 << PS_W) - 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        kick,
  input  ctrlStrobe_t strobe,
  output logic        rstReq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lastCnt;
  logic             clearCnt;
  logic             hitEnd;

  assign span     = (CNT_W + 1)'(1) << (BASE_LOG + int'(strobe.ps));
  assign lastCnt  = CNT_W'(span - (CNT_W + 1)'(1));
  assign clearCnt = kick || strobe.psLoad || !strobe.run;
  assign hitEnd   = !clearCnt && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= hitEnd;
      if (clearCnt || hitEnd) cnt <= '0;
      else                    cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int WIN      = 4,
  parameter int BASE_LOG = 10,
  localparam int PS_W    = PS_W_P,
  localparam int REG_W   = PS_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             safeLevelIn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             kick,
  output logic             rstReq
);
  ctrlStrobe_t strobe;
  logic        lvlQ;

  wdog_ctrl #(.WIN(WIN), .PS_W(PS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .safeLevelIn(safeLevelIn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lvlQ(lvlQ), .strobe(strobe)
  );

  wdog_count #(.BASE_LOG(BASE_LOG), .PS_W(PS_W)) u_count (
    .clk(clk), .rstN(rstN), .kick(kick), .strobe(strobe), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int WIN   = 4,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             lvlQ,
  input logic             wrEn,
  input logic [REG_W-1:0] rdData,
  input logic             rstReq
);
  logic [7:0] winRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     winRun <= '0;
    else if (!rdData[1] || wrEn)   winRun <= '0;
    else                           winRun <= winRun + 8'd1;
  end

  assert_strict_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    lvlQ |-> rdData[0]);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[0] |=> !rstReq);

  assert_ps_guarded_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdData[1]) |=> $stable(rdData[REG_W-1:2]));

  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1] |-> (winRun < 8'(WIN)));

  assert_disable_guarded_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[0]) |-> $past(rdData[1]));
endmodule

bind wdog_top wdog_chk #(.WIN(WIN), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .lvlQ(lvlQ), .wrEn(wrEn),
  .rdData(rdData), .rstReq(rstReq)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       safeLevelIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrData = '0;
  logic [4:0] rdData;
  logic       kick = 1'b0;
  logic       rstReq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_top u0 (
    .clk(clk), .rstN(rstN), .safeLevelIn(safeLevelIn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .kick(kick), .rstReq(rstReq)
  );

  // {idle gap[2:0], write value[4:0], expected readback[4:0]}
  localparam logic [12:0] VEC [0:10] = '{
    {3'd0, 5'h01, 5'h01},   // R1 plain enable
    {3'd0, 5'h0D, 5'h01},   // R7 select change rejected
    {3'd0, 5'h00, 5'h01},   // R2 disable rejected
    {3'd0, 5'h03, 5'h03},   // R3 window opens
    {3'd3, 5'h09, 5'h09},   // R4 last clock of window
    {3'd0, 5'h03, 5'h0B},   // R3 reopen
    {3'd4, 5'h00, 5'h09},   // R6 one clock too late
    {3'd0, 5'h03, 5'h0B},   // R3
    {3'd1, 5'h00, 5'h00},   // R2 disable accepted
    {3'd0, 5'h0C, 5'h00},   // R7 select guarded while off
    {3'd0, 5'h01, 5'h01}    // R1 enable again
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(logic lvl);
    @(negedge clk);
    safeLevelIn = lvl;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(logic [4:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (rstReq) break;
    end
  endtask

  task automatic countPulses(int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rstReq) hits++;
    end
  endtask

  initial begin
    int n;
    int hits;
    doReset(1'b0);
    check("R1 reset readback", 32'(rdData), 32'h00);
    check("R1 reset request low", 32'(rstReq), 32'h0);

    countPulses(2100, hits);
    check("R10 disabled no request", 32'(hits), 32'd0);

    for (int v = 0; v < 11; v++) begin
      idle(int'(VEC[v][12:10]));
      wrReg(VEC[v][9:5]);
      check($sformatf("R1-7 vector %0d (R2 R3 R4 R6 R7)", v),
            32'(rdData), 32'(VEC[v][4:0]));
    end

    doKick();
    waitPulse(n);
    check("R8 timeout select 0", 32'(n), 32'd1024);
    @(negedge clk);
    check("R8 pulse one clock", 32'(rstReq), 32'h0);
    waitPulse(n);
    check("R8 restart period", 32'(n), 32'd1023);

    for (int k = 0; k < 3; k++) begin
      doKick();
      countPulses(1000, hits);
      check("R9 kick holds off request", 32'(hits), 32'd0);
    end

    doKick();
    idle(500);
    wrReg(5'h03);
    wrReg(5'h05);
    check("R4 select 1 loaded", 32'(rdData), 32'h05);
    waitPulse(n);
    check("R9 select change clears, R8 select 1", 32'(n), 32'd2048);

    wrReg(5'h03);
    idle(3);
    check("R6 unlock bit held", 32'(rdData[1]), 32'h1);
    idle(1);
    check("R6 unlock bit self clears", 32'(rdData[1]), 32'h0);

    wrReg(5'h02);
    check("R3 partial pattern opens nothing", 32'(rdData), 32'h05);
    wrReg(5'h00);
    check("R3 following disable rejected", 32'(rdData), 32'h05);

    doReset(1'b1);
    check("R5 strict reset readback", 32'(rdData), 32'h01);
    wrReg(5'h00);
    check("R5 strict disable ignored", 32'(rdData), 32'h01);
    wrReg(5'h0C);
    check("R7 strict select guarded", 32'(rdData), 32'h01);
    wrReg(5'h03);
    check("R3 strict window opens", 32'(rdData), 32'h03);
    wrReg(5'h04);
    check("R5 strict second write enable ignored", 32'(rdData), 32'h05);
    waitPulse(n);
    check("R5 strict runs select 1", 32'(n), 32'd2048);

    safeLevelIn = 1'b0;
    wrReg(5'h03);
    wrReg(5'h00);
    check("R11 strap held after reset", 32'(rdData), 32'h01);

    doReset(1'b0);
    check("R11 strap retaken at reset", 32'(rdData), 32'h00);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule